// File: doc/BRIEF.md
# PTP Event Frame Timestamp Capture

This block sits beside one Ethernet port and watches the byte streams of frames going in and out. When a frame carries a layer-2 PTP event message, the block takes a copy of a free-running time counter at the first byte of the PTP header. It also keeps the message's sequence number. The copy goes into a capture slot that host software reads and then re-arms.

There are three slots. Two hold received frames. The message type named by a pointer register is sent to the second receive slot, and every other selected type goes to the first. The third slot holds transmitted frames. Each slot holds a single capture. A second qualifying frame that arrives while the slot is still full is recorded only as an overrun code, and the first capture stays in place. The host reaches the slots and the configuration through a 16-bit register port. The configuration is the matched ethertype, a mask of message types to capture, the steering pointer, and two disable bits, one for the port and one global.

Frames are presented one byte per cycle with a valid strobe and a last-byte marker. Byte 0 is the first byte of the destination address. The frame is untagged, so the ethertype is in bytes 12 and 13 and the PTP header starts at byte 14.

Top module: `ptpcap_unit`

## Requirements
- R1: After reset the register port reads as follows. Control (address 15) is 0x0003: bit 0 is the port disable and bit 1 is the global disable, and both are set. Ethertype (address 12) is 0x88F7. Type mask (address 13) is 0x0000. Steering pointer (address 14) is 0x0003. The status word of every slot is 0x0000.
- R2: A received frame qualifies when three things hold: bytes 12-13 (big-endian) equal the ethertype register, the mask bit selected by the low nibble of byte 14 is set, and both disables are clear. A qualifying received frame whose type differs from the pointer fills slot 0 (addresses 0-3). After the capture, the status word reads 0x0001 (bit 0 valid, bits 2:1 code 0). Words 1 and 2 hold the counter value present with byte 14, low half first. Word 3 holds bytes 44-45 taken big-endian.
- R3: A qualifying received frame whose type equals the pointer register fills slot 1 (addresses 4-7), and slot 0 does not change.
- R4: A qualifying transmitted frame fills slot 2 (addresses 8-11) with the same layout.
- R5: A frame whose type has its mask bit clear is not captured.
- R6: A frame whose ethertype differs from the register is not captured. After the register is reprogrammed, frames carrying the new value are captured.
- R7: A qualifying frame that reaches a slot which is already valid leaves the stored time and sequence unchanged and sets the code to 2, so the status reads 0x0005.
- R8: Writing zero to a slot's status word clears the valid bit and the code. Writing a non-zero value to a status word has no effect.
- R9: While either disable bit is set, no slot captures anything.
- R10: A frame that ends before byte 45 is discarded. The byte count restarts at the byte after any last-byte marker.
- R11: The ethertype, mask, pointer and control registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Receive byte strobe |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the last byte of a received frame |
| tx_valid | input | 1 | Transmit byte strobe |
| tx_data | input | 8 | Transmit byte |
| tx_last | input | 1 | Marks the last byte of a transmitted frame |
| time_count | input | 32 | Free-running time counter to sample |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |

## Verification
The bench builds the unit with its default parameters: a header offset of 14, a sequence offset of 30 within the header, and a 6-bit byte counter. With these values, frames of 46 bytes or more reach the commit byte and shorter ones stop short of it, so both the capture path and the discard path can be tested with ordinary frame lengths. A 4-bit type nibble lets random traffic cover all sixteen mask bits and any pointer value. A free time input driven with fresh random values on every byte shows whether the sample was taken at exactly byte 14.

// File: rtl/ptpcap_pkg.sv
// Shared widths, register addresses and the capture record type.
package ptpcap_pkg;
    localparam int TIME_W  = 32;
    localparam int SEQ_W   = 16;
    localparam int NSLOT   = 3;
    localparam int REG_AW  = 4;

    localparam logic [REG_AW-1:0] A_ETYPE = 4'd12;
    localparam logic [REG_AW-1:0] A_MASK  = 4'd13;
    localparam logic [REG_AW-1:0] A_PTR   = 4'd14;
    localparam logic [REG_AW-1:0] A_CTRL  = 4'd15;

    localparam logic [1:0] CODE_NORMAL  = 2'd0;
    localparam logic [1:0] CODE_OVERRUN = 2'd2;

    typedef struct packed {
        logic [SEQ_W-1:0]  seq;
        logic [TIME_W-1:0] stamp;
    } cap_rec_t;
endpackage

// File: rtl/ptpcap_parser.sv
// Byte-stream parser for one direction.
// Counts the bytes of each frame, matches the ethertype, samples the
// time input at the first PTP header byte and assembles the sequence id.
// On the byte that completes the sequence id it raises commit for one cycle,
// but only if the frame qualifies.
// Assumes untagged frames, one byte per valid cycle, and a last marker on
// the final byte of each frame.
module ptpcap_parser
    import ptpcap_pkg::*;
#(
    parameter int HDR_OFS = 14,
    parameter int SEQ_OFS = 30,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [TIME_W-1:0] stamp_in,
    input  logic [15:0]       etype_cfg,
    input  logic [15:0]       msg_mask,
    input  logic              enable,
    output logic              commit,
    output logic [3:0]        msg_type,
    output cap_rec_t          rec
);
    localparam logic [IDX_W-1:0] ET_HI  = IDX_W'(HDR_OFS - 2);
    localparam logic [IDX_W-1:0] ET_LO  = IDX_W'(HDR_OFS - 1);
    localparam logic [IDX_W-1:0] HDR0   = IDX_W'(HDR_OFS);
    localparam logic [IDX_W-1:0] SEQ_HI = IDX_W'(HDR_OFS + SEQ_OFS);
    localparam logic [IDX_W-1:0] SEQ_LO = IDX_W'(HDR_OFS + SEQ_OFS + 1);

    logic [IDX_W-1:0]  idx;
    logic [7:0]        et_hi;
    logic              etype_ok;
    logic [TIME_W-1:0] stamp_q;
    logic [3:0]        msg_q;
    logic [7:0]        seq_hi;

    // Byte position within the current frame; saturates, restarts after last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (in_valid) begin
            if (in_last)
                idx <= '0;
            else if (idx != '1)
                idx <= idx + 1'b1;
        end
    end

    // Capture the header fields that the qualification and record need.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            et_hi    <= '0;
            etype_ok <= 1'b0;
            stamp_q  <= '0;
            msg_q    <= '0;
            seq_hi   <= '0;
        end else if (in_valid) begin
            if (idx == ET_HI)  et_hi    <= in_data;
            if (idx == ET_LO)  etype_ok <= ({et_hi, in_data} == etype_cfg);
            if (idx == HDR0) begin
                stamp_q <= stamp_in;
                msg_q   <= in_data[3:0];
            end
            if (idx == SEQ_HI) seq_hi   <= in_data;
        end
    end

    // Commit decision on the last sequence byte.
    always_comb begin
        commit    = in_valid && (idx == SEQ_LO) && etype_ok && msg_mask[msg_q] && enable;
        msg_type  = msg_q;
        rec.seq   = {seq_hi, in_data};
        rec.stamp = stamp_q;
    end
endmodule

// File: rtl/ptpcap_slot.sv
// One capture slot: a valid flag, a status code and one record.
// A capture into an empty slot stores the record. A capture into a full
// slot keeps the old record and sets the overrun code. A clear empties the
// slot; a capture arriving in the same cycle as a clear is stored.
module ptpcap_slot
    import ptpcap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cap,
    input  cap_rec_t cap_rec,
    input  logic     clr,
    output logic     vld,
    output logic [1:0] code,
    output cap_rec_t rec
);
    // Slot state update: clear, fill or overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            code <= CODE_NORMAL;
            rec  <= '0;
        end else if (clr) begin
            vld  <= cap;
            code <= CODE_NORMAL;
            if (cap) rec <= cap_rec;
        end else if (cap) begin
            if (vld)
                code <= CODE_OVERRUN;
            else begin
                vld  <= 1'b1;
                code <= CODE_NORMAL;
                rec  <= cap_rec;
            end
        end
    end
endmodule

// File: rtl/ptpcap_unit.sv
// PTP event timestamp capture for one port.
// Contains a receive parser and a transmit parser, two arrival slots and
// one departure slot, the configuration registers and the register read
// mux. Received captures are steered by comparing their message type with
// the pointer register.
// Assumes the register port is used one access per cycle; reads are
// combinational.
module ptpcap_unit
    import ptpcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    input  logic              tx_last,
    input  logic [TIME_W-1:0] time_count,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata
);
    logic [15:0] etype_r, mask_r;
    logic [3:0]  ptr_r;
    logic        port_dis, glob_dis, cap_en;

    logic        rx_commit, tx_commit;
    logic [3:0]  rx_msg, tx_msg;
    cap_rec_t    rx_rec, tx_rec;

    logic [NSLOT-1:0]             slot_cap, slot_clr, slot_vld;
    logic [NSLOT-1:0][1:0]        slot_code;
    cap_rec_t [NSLOT-1:0]         slot_rec;
    logic [NSLOT-1:0][TIME_W-1:0] slot_stamp;
    logic [1:0]                   sel;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            etype_r  <= 16'h88F7;
            mask_r   <= '0;
            ptr_r    <= 4'd3;
            port_dis <= 1'b1;
            glob_dis <= 1'b1;
        end else if (reg_wr) begin
            case (reg_addr)
                A_ETYPE: etype_r <= reg_wdata;
                A_MASK:  mask_r  <= reg_wdata;
                A_PTR:   ptr_r   <= reg_wdata[3:0];
                A_CTRL:  {glob_dis, port_dis} <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    assign cap_en = !port_dis && !glob_dis;

    ptpcap_parser u_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_data(rx_data),
        .in_last(rx_last), .stamp_in(time_count), .etype_cfg(etype_r),
        .msg_mask(mask_r), .enable(cap_en), .commit(rx_commit),
        .msg_type(rx_msg), .rec(rx_rec)
    );

    ptpcap_parser u_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(tx_valid), .in_data(tx_data),
        .in_last(tx_last), .stamp_in(time_count), .etype_cfg(etype_r),
        .msg_mask(mask_r), .enable(cap_en), .commit(tx_commit),
        .msg_type(tx_msg), .rec(tx_rec)
    );

    // Steering: pointer type to arrival slot 1, other received types to slot 0.
    always_comb begin
        slot_cap[0] = rx_commit && (rx_msg != ptr_r);
        slot_cap[1] = rx_commit && (rx_msg == ptr_r);
        slot_cap[2] = tx_commit;
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign slot_clr[i] = reg_wr && (reg_addr == REG_AW'(i * 4)) && (reg_wdata == '0);
        ptpcap_slot u_slot (
            .clk(clk), .rst_n(rst_n), .cap(slot_cap[i]),
            .cap_rec((i == NSLOT - 1) ? tx_rec : rx_rec),
            .clr(slot_clr[i]), .vld(slot_vld[i]), .code(slot_code[i]),
            .rec(slot_rec[i])
        );
        assign slot_stamp[i] = slot_rec[i].stamp;
    end

    assign sel = reg_addr[3:2];

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        if (sel != 2'd3) begin
            case (reg_addr[1:0])
                2'd0: reg_rdata = {13'b0, slot_code[sel], slot_vld[sel]};
                2'd1: reg_rdata = slot_rec[sel].stamp[15:0];
                2'd2: reg_rdata = slot_rec[sel].stamp[TIME_W-1:16];
                default: reg_rdata = slot_rec[sel].seq;
            endcase
        end else begin
            case (reg_addr)
                A_ETYPE: reg_rdata = etype_r;
                A_MASK:  reg_rdata = mask_r;
                A_PTR:   reg_rdata = {12'b0, ptr_r};
                default: reg_rdata = {14'b0, glob_dis, port_dis};
            endcase
        end
    end
endmodule

// File: rtl/ptpcap_checker.sv
// Temporal checks on slot behaviour, bound into the capture unit.
module ptpcap_checker
    import ptpcap_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic [NSLOT-1:0]         cap,
    input logic [NSLOT-1:0]         clr,
    input logic [NSLOT-1:0]         vld,
    input logic [NSLOT-1:0][1:0]    code,
    input logic [NSLOT-1:0][TIME_W-1:0] stamp,
    input logic                     port_dis,
    input logic                     glob_dis
);
    assert_arrival_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap[1:0]));

    assert_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_dis || glob_dis) |-> (cap == '0));

    for (genvar i = 0; i < NSLOT; i++) begin : g_chk
        assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!vld[i] && cap[i]) |=> (vld[i] && code[i] == CODE_NORMAL));

        assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[i] && cap[i] && !clr[i]) |=> (vld[i] && code[i] == CODE_OVERRUN));

        assert_keep_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (vld[i] && !clr[i]) |=> $stable(stamp[i]));

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !cap[i]) |=> (!vld[i] && code[i] == CODE_NORMAL));
    end
endmodule

bind ptpcap_unit ptpcap_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cap(slot_cap), .clr(slot_clr), .vld(slot_vld),
    .code(slot_code), .stamp(slot_stamp), .port_dis(port_dis), .glob_dis(glob_dis)
);

// File: tb/ptpcap_unit_test.sv
module ptpcap_unit_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rx_last = 0, tx_valid = 0, tx_last = 0, reg_wr = 0;
    logic [7:0]  rx_data = 0, tx_data = 0;
    logic [31:0] time_count = 0;
    logic [3:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;

    int nchk = 0, nfail = 0;
    bit done = 0;

    // model state
    bit          m_vld [3];
    logic [1:0]  m_code[3];
    logic [31:0] m_time[3];
    logic [15:0] m_seq [3];
    logic [15:0] m_et = 16'h88F7, m_mask = 0;
    logic [3:0]  m_ptr = 4'd3;
    bit          m_en = 0;

    always #2 clk = ~clk;

    ptpcap_unit uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    function automatic logic [7:0] frame_byte(int b, logic [15:0] et, logic [3:0] msg, logic [15:0] seq);
        case (b)
            12: return et[15:8];
            13: return et[7:0];
            14: return {4'($urandom), msg};
            44: return seq[15:8];
            45: return seq[7:0];
            default: return 8'($urandom);
        endcase
    endfunction

    // Sends a frame and applies its expected effect to the model.
    task automatic send(input bit dir, input logic [15:0] et, input logic [3:0] msg,
                        input logic [15:0] seq, input int len);
        logic [31:0] t14 = 0;
        int s;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            time_count = $urandom;
            if (b == 14) t14 = time_count;
            if (dir) begin tx_valid = 1; tx_data = frame_byte(b, et, msg, seq); tx_last = (b == len-1); end
            else     begin rx_valid = 1; rx_data = frame_byte(b, et, msg, seq); rx_last = (b == len-1); end
        end
        @(negedge clk);
        rx_valid = 0; rx_last = 0; tx_valid = 0; tx_last = 0;
        s = dir ? 2 : ((msg == m_ptr) ? 1 : 0);
        if (len >= 46 && et == m_et && m_mask[msg] && m_en) begin
            if (m_vld[s]) m_code[s] = 2'd2;
            else begin m_vld[s] = 1; m_code[s] = 0; m_time[s] = t14; m_seq[s] = seq; end
        end
    endtask

    task automatic check_slot(input int s, input string req);
        logic [15:0] v;
        rd(4'(s*4), v);   check(req, v, {13'b0, m_code[s], m_vld[s]});
        rd(4'(s*4+1), v); check(req, v, m_time[s][15:0]);
        rd(4'(s*4+2), v); check(req, v, m_time[s][31:16]);
        rd(4'(s*4+3), v); check(req, v, m_seq[s]);
    endtask

    task automatic clear_slot(input int s);
        wr(4'(s*4), 16'h0);
        m_vld[s] = 0; m_code[s] = 0;
    endtask

    task automatic set_ctrl(input logic [1:0] c);
        wr(4'd15, {14'b0, c});
        m_en = (c == 2'b00);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) begin m_vld[i] = 0; m_code[i] = 0; m_time[i] = 0; m_seq[i] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(4'd15, v); check("R1 ctrl", v, 16'h0003);
        rd(4'd12, v); check("R1 etype", v, 16'h88F7);
        rd(4'd13, v); check("R1 mask", v, 16'h0000);
        rd(4'd14, v); check("R1 ptr", v, 16'h0003);
        for (int s = 0; s < 3; s++) check_slot(s, "R1 slot");

        // R11 readback
        wr(4'd13, 16'h000F); m_mask = 16'h000F;
        rd(4'd13, v); check("R11 mask", v, 16'h000F);
        wr(4'd14, 16'h0005); rd(4'd14, v); check("R11 ptr", v, 16'h0005);
        wr(4'd14, 16'h0003);
        wr(4'd12, 16'hABCD); rd(4'd12, v); check("R11 etype", v, 16'hABCD);
        wr(4'd12, 16'h88F7);

        // R9 disables
        send(0, 16'h88F7, 4'd0, 16'h1111, 50); check_slot(0, "R9 both dis");
        set_ctrl(2'b01); send(0, 16'h88F7, 4'd0, 16'h1112, 50); check_slot(0, "R9 port dis");
        rd(4'd15, v); check("R11 ctrl", v, 16'h0001);
        set_ctrl(2'b10); send(1, 16'h88F7, 4'd0, 16'h1113, 50); check_slot(2, "R9 global dis");
        set_ctrl(2'b00);

        // R2 basic arrival capture
        send(0, 16'h88F7, 4'd0, 16'hBEEF, 46); check_slot(0, "R2 arrival");
        // R7 overrun keeps first
        send(0, 16'h88F7, 4'd1, 16'h5A5A, 60); check_slot(0, "R7 overrun");
        // R8 nonzero write ignored, zero write clears
        wr(4'd0, 16'h0001); check_slot(0, "R8 nonzero write");
        clear_slot(0); check_slot(0, "R8 clear");
        // R3 steering
        send(0, 16'h88F7, 4'd3, 16'h0303, 48); check_slot(1, "R3 slot1"); check_slot(0, "R3 slot0 untouched");
        // R4 departure
        send(1, 16'h88F7, 4'd2, 16'hD00D, 46); check_slot(2, "R4 departure");
        // R5 mask clear
        send(0, 16'h88F7, 4'd8, 16'h0808, 50); check_slot(0, "R5 masked");
        // R6 ethertype mismatch and reprogram
        send(0, 16'h1234, 4'd0, 16'h1234, 50); check_slot(0, "R6 mismatch");
        wr(4'd12, 16'h1234); m_et = 16'h1234;
        send(0, 16'h1234, 4'd0, 16'h4321, 50); check_slot(0, "R6 reprogrammed");
        wr(4'd12, 16'h88F7); m_et = 16'h88F7;
        clear_slot(0);
        // R10 short frames discarded, count restarts
        send(0, 16'h88F7, 4'd0, 16'h0A0A, 45); check_slot(0, "R10 short 45");
        send(0, 16'h88F7, 4'd0, 16'h0B0B, 20);
        send(0, 16'h88F7, 4'd0, 16'h0C0C, 47); check_slot(0, "R10 restart");

        // Random traffic
        for (int n = 0; n < 80; n++) begin
            bit dir;
            logic [3:0] msg;
            logic [15:0] et;
            int len;
            if (($urandom % 8) == 0) begin
                m_mask = 16'($urandom); wr(4'd13, m_mask);
            end
            if (($urandom % 10) == 0) begin
                m_ptr = 4'($urandom); wr(4'd14, {12'b0, m_ptr});
            end
            dir = 1'($urandom);
            msg = 4'($urandom);
            et  = (($urandom % 6) == 0) ? 16'h8100 : 16'h88F7;
            len = (($urandom % 5) == 0) ? 30 + ($urandom % 16) : 46 + ($urandom % 20);
            send(dir, et, msg, 16'($urandom), len);
            for (int s = 0; s < 3; s++) check_slot(s, "R2/R7 random");
            for (int s = 0; s < 3; s++) if (($urandom % 3) == 0) clear_slot(s);
        end

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule